// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block is a watchdog on a simple register bus. The bus has an address, write data, separate write and read strobes, and read data. A fixed divide-by-4 prescaler drives a 24-bit down-counter. A valid feed reloads the counter from a programmable timeout register. A valid feed is a two-write key sequence to a dedicated feed address. When the counter expires, the block raises a sticky timeout flag. It can also drive a system reset pulse of fixed length.

Software first sets the enable bit, and can also set the reset-enable bit. Setting enable does not arm the watchdog: it arms only after the first valid key sequence that follows. After that, no register write can stop the counter. While the watchdog is armed with reset-enable set, a broken key sequence triggers the reset pulse at once. Only the external reset input clears the block's state. The watchdog's own reset output does not.

Top module: `wdt_keyed_feed`

## Requirements
- R1: After external reset, the control register (offset 0x0) reads 0, the limit register (offset 0x4) reads 0x0000FF, the count register (offset 0xC) reads 0, and both `wd_reset_o` and `expired_o` are low.
- R2: A write to the limit register keeps write-data bits [23:0] and ignores bits [31:24]. A value below 0x0000FF is stored as 0x0000FF. The stored value reads back at offset 0x4.
- R3: Control bit 0 (enable) and bit 1 (reset-enable) are set-only. Writing 1 sets the bit. Writing 0 leaves it unchanged until external reset. Both read back in bits [1:0] of offset 0x0.
- R4: A feed is valid when a write of 0xAA to offset 0x8 is followed, as the next bus access, by a write of 0x55 to offset 0x8. Only write-data bits [7:0] are compared. A valid feed loads the counter with the limit value.
- R5: The counter does not change before the watchdog is armed. Arming needs a valid feed completed while enable is already set. A feed made before enable is set does not arm.
- R6: While armed, the counter decrements once every 4 clock cycles. The prescaler restarts at each valid feed. The counter therefore reaches 0 exactly 4×limit cycles after the edge that accepts the 0x55 write.
- R7: When the armed counter reaches 0, `expired_o` goes high in that same cycle and stays high until external reset. The counter holds at 0 until the next valid feed reloads it.
- R8: On expiry with reset-enable set, `wd_reset_o` is high for exactly RST_CYCLES (default 8) cycles. With reset-enable clear, expiry produces no pulse.
- R9: After a 0xAA feed write, any other bus access aborts the sequence. This covers a read at any offset, a write to another offset, or a feed write of any other value. A later lone 0x55 write does not reload the counter.
- R10: A broken key sequence while armed with reset-enable set raises `wd_reset_o` on the edge of the offending access, and leaves `expired_o` unchanged. When the watchdog is unarmed, or reset-enable is clear, a broken sequence produces no pulse.
- R11: The count register is read-only. Writes to offset 0xC have no effect.
- R12: Once armed, writing 0 to the control register does not stop the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External power-on reset, active low |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational, zero when no read |
| wd_reset_o | output | 1 | System reset request pulse |
| expired_o | output | 1 | Sticky timeout flag |

## Verification
The assertions check, on every cycle, these properties:
- the set-only enable, reset-enable and armed bits;
- the floor on the limit register;
- a frozen counter while unarmed;
- a decrement step of at most one per cycle while armed;
- tick spacing;
- the immediate pulse after a broken sequence while armed.

Only the bench scenarios can show the behaviours that depend on exact timing or on ordering. These are the precise 4×limit expiry time, the exact pulse length, and the aborting of a key sequence by an intervening access. They also include the need for enable to come before the arming feed, and the silent expiry when reset-enable is clear.

// File: rtl/wdtk_pkg.sv
`timescale 1ns/1ps
package wdtk_pkg;
    localparam int OFS_CTRL  = 'h0;
    localparam int OFS_LIMIT = 'h4;
    localparam int OFS_KEY   = 'h8;
    localparam int OFS_COUNT = 'hC;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    localparam int LIMIT_FLOOR = 'hFF;

    typedef enum logic {
        KS_IDLE,
        KS_HALF
    } key_state_e;
endpackage

// File: rtl/wdtk_prescale.sv
`timescale 1ns/1ps
module wdtk_prescale #(
    parameter int DIV_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    logic [DIV_W-1:0] phase_d, phase_q;

    assign tick = run && (phase_q == {DIV_W{1'b1}});

    always_comb begin
        phase_d = phase_q;
        if (restart) begin
            phase_d = '0;
        end else if (run) begin
            phase_d = phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R6
endmodule

// File: rtl/wdtk_key_seq.sv
`timescale 1ns/1ps
module wdtk_key_seq
    import wdtk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       access,
    input  logic       key_wr,
    input  logic [7:0] key,
    output logic       feed_ok,
    output logic       feed_err
);
    key_state_e st_d, st_q;

    always_comb begin
        st_d     = st_q;
        feed_ok  = 1'b0;
        feed_err = 1'b0;
        if (access) begin
            if (st_q == KS_HALF) begin
                st_d = KS_IDLE;
                if (key_wr && key == KEY_SECOND) begin
                    feed_ok = 1'b1;
                end else begin
                    feed_err = 1'b1;
                end
            end else if (key_wr && key == KEY_FIRST) begin
                st_d = KS_HALF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= KS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    AST_HALF_RESOLVES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == KS_HALF && access) |-> (feed_ok != feed_err)); // R9
endmodule

// File: rtl/wdtk_core.sv
`timescale 1ns/1ps
module wdtk_core
    import wdtk_pkg::*;
#(
    parameter int CNT_W      = 24,
    parameter int RST_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [1:0]       ctrl_bits,
    input  logic             limit_wr,
    input  logic [CNT_W-1:0] limit_val,
    input  logic             feed_ok,
    input  logic             feed_err,
    input  logic             tick,
    output logic             enable,
    output logic             reset_en,
    output logic             armed,
    output logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             expired,
    output logic             wd_reset
);
    localparam int PW = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(LIMIT_FLOOR);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    typedef struct packed {
        logic             en;
        logic             rst_en;
        logic             armed;
        logic [CNT_W-1:0] limit;
        logic [CNT_W-1:0] cnt;
        logic             expired;
        logic [PW-1:0]    pulse;
    } core_state_t;

    core_state_t d, q;

    always_comb begin
        d = q;
        if (q.pulse != '0) begin
            d.pulse = q.pulse - 1'b1;
        end
        if (ctrl_wr) begin
            d.en     = q.en | ctrl_bits[0];
            d.rst_en = q.rst_en | ctrl_bits[1];
        end
        if (limit_wr) begin
            d.limit = (limit_val < FLOOR) ? FLOOR : limit_val;
        end
        if (q.armed && tick && q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == ONE) begin
                d.expired = 1'b1;
                if (q.rst_en) begin
                    d.pulse = PW'(RST_CYCLES);
                end
            end
        end
        if (feed_ok) begin
            d.cnt = q.limit;
            if (q.en) begin
                d.armed = 1'b1;
            end
        end
        if (feed_err && q.armed && q.rst_en) begin
            d.pulse = PW'(RST_CYCLES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{en: 1'b0, rst_en: 1'b0, armed: 1'b0, limit: FLOOR,
                   cnt: '0, expired: 1'b0, pulse: '0};
        end else begin
            q <= d;
        end
    end

    assign enable   = q.en;
    assign reset_en = q.rst_en;
    assign armed    = q.armed;
    assign limit    = q.limit;
    assign count    = q.cnt;
    assign expired  = q.expired;
    assign wd_reset = (q.pulse != '0);

    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        q.en |=> q.en); // R3
    AST_RSTEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        q.rst_en |=> q.rst_en); // R3
    AST_LIMIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        q.limit >= FLOOR); // R2
    AST_ARM_NEEDS_FEED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.armed) |-> $past(feed_ok && q.en)); // R5
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.armed && !feed_ok) |=> $stable(q.cnt)); // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.armed && !feed_ok) |=> (q.cnt == $past(q.cnt) || q.cnt == $past(q.cnt) - ONE)); // R6
    AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        q.armed |=> q.armed); // R12
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        q.expired |=> q.expired); // R7
    AST_PULSE_NEEDS_RSTEN: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset |-> q.rst_en); // R8
    AST_ERR_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (feed_err && q.armed && q.rst_en) |=> wd_reset); // R10
endmodule

// File: rtl/wdt_keyed_feed.sv
`timescale 1ns/1ps
module wdt_keyed_feed
    import wdtk_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 24,
    parameter int RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_reset_o,
    output logic              expired_o
);
    logic             hit_ctrl, hit_limit, hit_key, hit_count;
    logic             feed_ok, feed_err, tick;
    logic             enable, reset_en, armed;
    logic [CNT_W-1:0] limit, count;
    logic             unused_wdata_hi;

    assign hit_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_limit = (bus_addr == ADDR_W'(OFS_LIMIT));
    assign hit_key   = (bus_addr == ADDR_W'(OFS_KEY));
    assign hit_count = (bus_addr == ADDR_W'(OFS_COUNT));
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

    wdtk_prescale #(.DIV_W(2)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (armed),
        .restart (feed_ok),
        .tick    (tick)
    );

    wdtk_key_seq u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .access   (bus_wr | bus_rd),
        .key_wr   (bus_wr && hit_key),
        .key      (bus_wdata[7:0]),
        .feed_ok  (feed_ok),
        .feed_err (feed_err)
    );

    wdtk_core #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (bus_wr && hit_ctrl),
        .ctrl_bits (bus_wdata[1:0]),
        .limit_wr  (bus_wr && hit_limit),
        .limit_val (bus_wdata[CNT_W-1:0]),
        .feed_ok   (feed_ok),
        .feed_err  (feed_err),
        .tick      (tick),
        .enable    (enable),
        .reset_en  (reset_en),
        .armed     (armed),
        .limit     (limit),
        .count     (count),
        .expired   (expired_o),
        .wd_reset  (wd_reset_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_ctrl) begin
                bus_rdata = DATA_W'({reset_en, enable});
            end else if (hit_limit) begin
                bus_rdata = DATA_W'(limit);
            end else if (hit_count) begin
                bus_rdata = DATA_W'(count);
            end
        end
    end

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd)); // R9
endmodule

// File: tb/tb_wdt_keyed_feed.sv
`timescale 1ns/1ps
module tb_wdt_keyed_feed;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        wd_reset_o, expired_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    wdt_keyed_feed dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .wd_reset_o(wd_reset_o), .expired_o(expired_o)
    );

    localparam logic [63:0] LIMIT_VEC [8] = '{
        {32'h0000_0000, 32'h0000_00FF},
        {32'h0000_0010, 32'h0000_00FF},
        {32'h0000_00FE, 32'h0000_00FF},
        {32'h0000_00FF, 32'h0000_00FF},
        {32'h0000_0100, 32'h0000_0100},
        {32'h00FF_FFFF, 32'h00FF_FFFF},
        {32'hFF00_0123, 32'h0000_0123},
        {32'h12AB_CDEF, 32'h00AB_CDEF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bwr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic feed();
        bwr(4'h8, 32'hAA);
        bwr(4'h8, 32'h55);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        // Phase A: reset state, limit handling, key sequences while unarmed
        do_reset();
        brd(4'h0, rv); chk("R1 ctrl", rv, 32'h0);
        brd(4'h4, rv); chk("R1 limit", rv, 32'hFF);
        brd(4'hC, rv); chk("R1 count", rv, 32'h0);
        chk("R1 outputs", {30'b0, wd_reset_o, expired_o}, 32'h0);

        for (int i = 0; i < 8; i++) begin
            bwr(4'h4, LIMIT_VEC[i][63:32]);
            brd(4'h4, rv);
            chk("R2 limit write", rv, LIMIT_VEC[i][31:0]);
        end

        bwr(4'hC, 32'h1234); brd(4'hC, rv); chk("R11 count read-only", rv, 32'h0);

        bwr(4'h4, 32'h300);
        bwr(4'h8, 32'hAA); brd(4'hC, rv);
        chk("R10 no pulse unarmed", {31'b0, wd_reset_o}, 32'h0);
        bwr(4'h8, 32'h55); brd(4'hC, rv); chk("R9 read aborts", rv, 32'h0);
        bwr(4'h8, 32'hAA); bwr(4'h8, 32'h12); bwr(4'h8, 32'h55);
        brd(4'hC, rv); chk("R9 wrong key aborts", rv, 32'h0);
        bwr(4'h8, 32'hAA); bwr(4'h4, 32'h300); bwr(4'h8, 32'h55);
        brd(4'hC, rv); chk("R9 other write aborts", rv, 32'h0);
        bwr(4'h8, 32'hFFFF_FFAA); bwr(4'h8, 32'h1234_5655);
        brd(4'hC, rv); chk("R4 valid feed reload", rv, 32'h300);
        repeat (40) @(posedge clk);
        brd(4'hC, rv); chk("R5 fed before enable stays", rv, 32'h300);
        bwr(4'h0, 32'h1);
        repeat (40) @(posedge clk);
        brd(4'hC, rv); chk("R5 enable without feed stays", rv, 32'h300);

        // Phase B: arming, rate, expiry with pulse
        do_reset();
        bwr(4'h0, 32'h3); brd(4'h0, rv); chk("R3 set bits", rv, 32'h3);
        bwr(4'h0, 32'h0); brd(4'h0, rv); chk("R3 zero ignored", rv, 32'h3);
        repeat (50) @(posedge clk);
        brd(4'hC, rv); chk("R5 not armed", rv, 32'h0);
        chk("R5 no expiry unarmed", {31'b0, expired_o}, 32'h0);
        feed();
        repeat (8) @(posedge clk);
        brd(4'hC, rv); chk("R6 rate", rv, 32'hFD);
        repeat (1010) @(posedge clk);
        @(negedge clk);
        chk("R7 flag before expiry", {31'b0, expired_o}, 32'h0);
        chk("R8 no pulse before expiry", {31'b0, wd_reset_o}, 32'h0);
        @(posedge clk); #1;
        chk("R7 flag at expiry", {31'b0, expired_o}, 32'h1);
        chk("R8 pulse at expiry", {31'b0, wd_reset_o}, 32'h1);
        n = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (wd_reset_o) n++;
            else break;
        end
        chk("R8 pulse length", n, 32'd8);
        brd(4'hC, rv); chk("R7 count holds zero", rv, 32'h0);
        repeat (20) @(posedge clk);
        brd(4'hC, rv); chk("R7 count still zero", rv, 32'h0);
        chk("R7 flag sticky", {31'b0, expired_o}, 32'h1);
        feed();
        bwr(4'h0, 32'h0);
        repeat (20) @(posedge clk);
        brd(4'hC, rv); chk("R12 still counting", rv, 32'hFA);

        // Phase C: broken sequences while armed
        do_reset();
        bwr(4'h4, 32'h200); bwr(4'h0, 32'h1); feed();
        bwr(4'h8, 32'hAA); brd(4'h0, rv);
        chk("R10 no pulse without reset-enable", {31'b0, wd_reset_o}, 32'h0);
        bwr(4'h0, 32'h2);
        bwr(4'h8, 32'hAA); bwr(4'h8, 32'h33);
        chk("R10 bad key resets", {31'b0, wd_reset_o}, 32'h1);
        chk("R10 flag untouched", {31'b0, expired_o}, 32'h0);

        // Phase D: expiry without reset-enable
        do_reset();
        bwr(4'h0, 32'h1); feed();
        n = 0;
        repeat (1040) begin
            @(negedge clk);
            if (wd_reset_o) n++;
        end
        chk("R8 silent expiry", n, 32'd0);
        chk("R7 flag silent expiry", {31'b0, expired_o}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule